// File: doc/BRIEF.md
# Bidirectional Accumulator Shifter

This block keeps a small file of wide accumulators. Each accumulator is built from a high half and a low half. A single request shifts the selected accumulator by a signed amount: a positive amount moves bits toward the low end, and a negative amount moves them toward the high end. The amount comes from one of two sources. The first is a short immediate field. The second is the low bits of a full register operand, and the remaining bits of that operand play no part.

Software fills the accumulators through separate high-half and low-half write strobes that share one data bus and one index. It reads an accumulator back through a combinational read port that returns both halves at once. A shift finishes in a single clock edge. When a shift and a write land on the same accumulator in the same cycle, the shift wins.

Top module: `acc_shift_file`

## Requirements
- R1: After reset every accumulator reads back as HI=0 and LO=0.
- R2: The shift amount is a 6-bit two's-complement value. With `shift_src`=0 it is `shift_imm`. With `shift_src`=1 it is bits [5:0] of `shift_reg`, and bits [31:6] have no effect, so 0xFFFFFFFF means -1.
- R3: An amount from +1 to +31 shifts the 64-bit value {HI,LO} right by that many bits, filling the top with zeros.
- R4: An amount from -1 to -32 shifts {HI,LO} left by the magnitude, filling the bottom with zeros. At -32 the old LO becomes HI and LO becomes 0.
- R5: An amount of zero leaves both HI and LO of the selected accumulator unchanged.
- R6: The shift operand is HI in bits [63:32] and LO in bits [31:0], and the result is split back the same way. For example, HI=0x00000001 and LO=0x80000000 shifted by -1 give HI=0x00000003 and LO=0x00000000.
- R7: A shift changes only the accumulator selected by `shift_idx`, and every index 0 to 3 works.
- R8: `wr_hi_en` writes `wr_data` into the HI half of accumulator `wr_idx`, and `wr_lo_en` writes it into the LO half. Each takes effect at the next rising edge and leaves the other half as it was.
- R9: `rd_hi` and `rd_lo` show accumulator `rd_idx` combinationally, with no clock edge in between.
- R10: When `shift_req` is high and `wr_idx` equals `shift_idx`, the write is dropped and the shift result is stored. A write to a different index in the same cycle is still applied.
- R11: The shift result can be read from the port in the cycle after the rising edge that samples `shift_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_req | input | 1 | Shift the selected accumulator this cycle |
| shift_src | input | 1 | Amount source: 0 = immediate, 1 = register |
| shift_imm | input | 6 | Immediate signed amount |
| shift_reg | input | 32 | Register operand; only bits [5:0] are used |
| shift_idx | input | 2 | Accumulator to shift |
| wr_hi_en | input | 1 | Write the HI half |
| wr_lo_en | input | 1 | Write the LO half |
| wr_idx | input | 2 | Accumulator to write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 2 | Accumulator to read |
| rd_hi | output | 32 | HI half of the read accumulator |
| rd_lo | output | 32 | LO half of the read accumulator |

## Verification
Shifts and writes commit on the first rising edge after they are applied. Reads carry no latency. The driver applies each operation at a falling edge and queues the expected read value tagged with the cycle number of the next rising edge. The monitor pops an entry only when that cycle count is reached, and it compares the entry with the read port 1 ns after the edge. The combinational read path is checked separately: the bench changes `rd_idx` with no clock edge and samples shortly afterwards.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

   typedef enum logic {
      SRC_IMM = 1'b0,
      SRC_REG = 1'b1
   } amt_src_e;

   localparam int unsigned DEF_HALF_W  = 32;
   localparam int unsigned DEF_AMT_W   = 6;
   localparam int unsigned DEF_NUM_ACC = 4;

endpackage

// File: rtl/acc_amount_decode.sv
module acc_amount_decode
   import acc_shift_pkg::*;
#(
   parameter int unsigned AMT_W = 6,
   parameter int unsigned REG_W = 32
) (
   input  amt_src_e         src,
   input  logic [AMT_W-1:0] imm,
   input  logic [REG_W-1:0] reg_val,
   output logic             is_zero,
   output logic             go_left,
   output logic [AMT_W-1:0] mag
);

   if (AMT_W < 2) begin : g_bad_amt
      $error("acc_amount_decode: AMT_W must be at least 2");
   end
   if (AMT_W > REG_W) begin : g_bad_reg
      $error("acc_amount_decode: AMT_W must not exceed REG_W");
   end

   logic [AMT_W-1:0] raw;

   always_comb begin
      if (src == SRC_REG) begin
         raw = reg_val[AMT_W-1:0];
      end else begin
         raw = imm;
      end
      go_left = raw[AMT_W-1];
      is_zero = (raw == '0);
      if (go_left) begin
         mag = (~raw) + AMT_W'(1);
      end else begin
         mag = raw;
      end
   end

   // R4: a negative code never yields a zero magnitude
   always_comb begin
      p_left_mag_nonzero_r4: assert (!go_left || (mag != '0))
         else $error("left shift decoded with zero magnitude");
   end

endmodule

// File: rtl/acc_bidir_shift.sv
module acc_bidir_shift #(
   parameter int unsigned ACC_W      = 64,
   parameter int unsigned AMT_W      = 6,
   parameter bit          USE_STAGES = 1'b1
) (
   input  logic [ACC_W-1:0] din,
   input  logic             go_left,
   input  logic [AMT_W-1:0] mag,
   output logic [ACC_W-1:0] dout
);

   localparam int unsigned MAX_MAG = 1 << (AMT_W - 1);

   if (MAX_MAG >= ACC_W) begin : g_bad_width
      $error("acc_bidir_shift: largest magnitude must stay below ACC_W");
   end

   function automatic logic [ACC_W-1:0] flip(input logic [ACC_W-1:0] v);
      logic [ACC_W-1:0] r;
      for (int b = 0; b < ACC_W; b++) begin
         r[b] = v[ACC_W-1-b];
      end
      return r;
   endfunction

   if (USE_STAGES) begin : g_staged
      // One right-shifting log ladder; left shifts reverse the bit order around it.
      logic [ACC_W-1:0] stg [AMT_W+1];

      assign stg[0] = go_left ? flip(din) : din;

      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int unsigned STEP = 1 << k;
         assign stg[k+1] = mag[k] ? (stg[k] >> STEP) : stg[k];
      end

      assign dout = go_left ? flip(stg[AMT_W]) : stg[AMT_W];
   end else begin : g_direct
      always_comb begin
         if (go_left) begin
            dout = din << mag;
         end else begin
            dout = din >> mag;
         end
      end
   end

   // R3 / R4: the vacated bit positions must hold zeros
   always_comb begin
      if (mag != '0) begin
         p_right_zero_fill_r3: assert (go_left || ((dout >> (ACC_W - mag)) == '0))
            else $error("right shift left nonzero bits at the top");
         p_left_zero_fill_r4: assert (!go_left || ((dout << (ACC_W - mag)) == '0))
            else $error("left shift left nonzero bits at the bottom");
      end
   end

endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
   parameter int unsigned NUM_ACC = 4,
   parameter int unsigned HALF_W  = 32,
   localparam int unsigned ACC_W  = 2 * HALF_W,
   localparam int unsigned IDX_W  = $clog2(NUM_ACC)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           upd_en,
   input  logic [IDX_W-1:0]               upd_idx,
   input  logic [ACC_W-1:0]               upd_val,
   input  logic                           wr_hi_en,
   input  logic                           wr_lo_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [HALF_W-1:0]              wr_data,
   output logic [NUM_ACC-1:0][ACC_W-1:0]  acc_q
);

   if (NUM_ACC < 2 || (NUM_ACC & (NUM_ACC - 1)) != 0) begin : g_bad_depth
      $error("acc_bank: NUM_ACC must be a power of two and at least 2");
   end

   for (genvar i = 0; i < NUM_ACC; i++) begin : g_entry
      logic sh_hit;
      logic wr_hit;

      assign sh_hit = upd_en && (upd_idx == IDX_W'(i));
      assign wr_hit = (wr_idx == IDX_W'(i)) && !sh_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q[i] <= '0;
         end else if (sh_hit) begin
            acc_q[i] <= upd_val;
         end else begin
            if (wr_hit && wr_hi_en) begin
               acc_q[i][ACC_W-1:HALF_W] <= wr_data;
            end
            if (wr_hit && wr_lo_en) begin
               acc_q[i][HALF_W-1:0] <= wr_data;
            end
         end
      end
   end

endmodule

// File: rtl/acc_shift_file.sv
module acc_shift_file
   import acc_shift_pkg::*;
#(
   parameter int unsigned HALF_W     = DEF_HALF_W,
   parameter int unsigned AMT_W      = DEF_AMT_W,
   parameter int unsigned NUM_ACC    = DEF_NUM_ACC,
   parameter bit          USE_STAGES = 1'b1,
   localparam int unsigned ACC_W     = 2 * HALF_W,
   localparam int unsigned IDX_W     = $clog2(NUM_ACC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_req,
   input  logic              shift_src,
   input  logic [AMT_W-1:0]  shift_imm,
   input  logic [HALF_W-1:0] shift_reg,
   input  logic [IDX_W-1:0]  shift_idx,
   input  logic              wr_hi_en,
   input  logic              wr_lo_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [HALF_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HALF_W-1:0] rd_hi,
   output logic [HALF_W-1:0] rd_lo
);

   logic [NUM_ACC-1:0][ACC_W-1:0] acc_all;
   logic [ACC_W-1:0]              sel_acc;
   logic [ACC_W-1:0]              shifted;
   logic [ACC_W-1:0]              shift_val;
   logic                          amt_zero;
   logic                          amt_left;
   logic [AMT_W-1:0]              amt_mag;

   acc_amount_decode #(
      .AMT_W (AMT_W),
      .REG_W (HALF_W)
   ) u_dec (
      .src     (amt_src_e'(shift_src)),
      .imm     (shift_imm),
      .reg_val (shift_reg),
      .is_zero (amt_zero),
      .go_left (amt_left),
      .mag     (amt_mag)
   );

   assign sel_acc = acc_all[shift_idx];

   acc_bidir_shift #(
      .ACC_W      (ACC_W),
      .AMT_W      (AMT_W),
      .USE_STAGES (USE_STAGES)
   ) u_shift (
      .din     (sel_acc),
      .go_left (amt_left),
      .mag     (amt_mag),
      .dout    (shifted)
   );

   // A zero amount keeps the old value while still claiming the entry this cycle.
   assign shift_val = amt_zero ? sel_acc : shifted;

   acc_bank #(
      .NUM_ACC (NUM_ACC),
      .HALF_W  (HALF_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (shift_req),
      .upd_idx  (shift_idx),
      .upd_val  (shift_val),
      .wr_hi_en (wr_hi_en),
      .wr_lo_en (wr_lo_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .acc_q    (acc_all)
   );

   assign rd_hi = acc_all[rd_idx][ACC_W-1:HALF_W];
   assign rd_lo = acc_all[rd_idx][HALF_W-1:0];

   // R11 / R10: the shift result lands one edge later, ahead of any same-index write
   p_shift_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      shift_req |=> acc_all[$past(shift_idx)] == $past(shift_val));

   // R5: a zero amount keeps the entry as it was
   p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_req && amt_zero) |=> acc_all[$past(shift_idx)] == $past(sel_acc));

   // R8: half writes land when no shift claims the entry
   p_write_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_en && !(shift_req && shift_idx == wr_idx))
      |=> acc_all[$past(wr_idx)][ACC_W-1:HALF_W] == $past(wr_data));

   p_write_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_en && !(shift_req && shift_idx == wr_idx))
      |=> acc_all[$past(wr_idx)][HALF_W-1:0] == $past(wr_data));

   // R7: entries that nobody targets stay put
   for (genvar i = 0; i < NUM_ACC; i++) begin : g_chk
      p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!(shift_req && shift_idx == IDX_W'(i)) &&
          !((wr_hi_en || wr_lo_en) && wr_idx == IDX_W'(i)))
         |=> $stable(acc_all[i]));
   end

endmodule

// File: tb/tb_acc_shift_file.sv
module tb_acc_shift_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        shift_req = 1'b0;
   logic        shift_src = 1'b0;
   logic [5:0]  shift_imm = '0;
   logic [31:0] shift_reg = '0;
   logic [1:0]  shift_idx = '0;
   logic        wr_hi_en = 1'b0;
   logic        wr_lo_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_idx = '0;
   logic [31:0] rd_hi;
   logic [31:0] rd_lo;

   always #2 clk = ~clk;

   acc_shift_file dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_req (shift_req),
      .shift_src (shift_src),
      .shift_imm (shift_imm),
      .shift_reg (shift_reg),
      .shift_idx (shift_idx),
      .wr_hi_en  (wr_hi_en),
      .wr_lo_en  (wr_lo_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_hi     (rd_hi),
      .rd_lo     (rd_lo)
   );

   typedef struct packed {
      int          due;
      logic [31:0] hi;
      logic [31:0] lo;
   } exp_t;

   exp_t        exp_q [$];
   string       tag_q [$];
   logic [63:0] model [4];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [63:0] ref_shift(input logic [63:0] a, input logic [5:0] code);
      int s;
      s = int'($signed(code));
      if (s > 0) return a >> s;
      if (s < 0) return a << (-s);
      return a;
   endfunction

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // monitor: pops entries when their cycle arrives
   always @(posedge clk) begin
      #1;
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (rd_hi !== e.hi || rd_lo !== e.lo) begin
            n_fail++;
            $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h", t, rd_hi, rd_lo, e.hi, e.lo);
         end
      end
   end

   // driver: one operation per cycle, expected read value due after the next edge
   task automatic op(input bit sh, input bit src, input logic [5:0] imm,
                     input logic [31:0] rv, input logic [1:0] sidx,
                     input bit whi, input bit wlo, input logic [1:0] widx,
                     input logic [31:0] wd, input logic [1:0] ridx, input string tag);
      logic [63:0] nv;
      logic [5:0]  code;
      bit          blocked;
      exp_t        e;
      @(negedge clk);
      shift_req = sh;  shift_src = src; shift_imm = imm; shift_reg = rv; shift_idx = sidx;
      wr_hi_en = whi;  wr_lo_en = wlo;  wr_idx = widx;   wr_data = wd;    rd_idx = ridx;
      code    = src ? rv[5:0] : imm;
      blocked = sh && (widx == sidx);
      nv      = ref_shift(model[sidx], code);
      if (whi && !blocked) model[widx][63:32] = wd;
      if (wlo && !blocked) model[widx][31:0]  = wd;
      if (sh) model[sidx] = nv;
      e.due = cyc + 1;
      e.hi  = model[ridx][63:32];
      e.lo  = model[ridx][31:0];
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle;
      @(negedge clk);
      shift_req = 1'b0; wr_hi_en = 1'b0; wr_lo_en = 1'b0;
   endtask

   task automatic drain;
      while (exp_q.size() > 0) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         report();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every entry
      for (int i = 0; i < 4; i++) op(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'(i), "R1 reset");

      // R6: documented example with an immediate -1 on index 2
      op(0, 0, 0, 0, 0, 1, 0, 2, 32'h0000_0001, 2, "R8 write hi");
      op(0, 0, 0, 0, 0, 0, 1, 2, 32'h8000_0000, 2, "R8 write lo");
      op(1, 0, 6'h3F, 0, 2, 0, 0, 0, 0, 2, "R6 example hi=3 lo=0");
      // R2: register source, all-ones register means -1, on index 1
      op(0, 0, 0, 0, 0, 1, 0, 1, 32'h0000_0001, 1, "R8 write hi");
      op(0, 0, 0, 0, 0, 0, 1, 1, 32'h8000_0000, 1, "R8 write lo");
      op(1, 1, 0, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 1, "R2 reg 0xFFFFFFFF");
      // R8: a hi write leaves lo alone
      op(0, 0, 0, 0, 0, 1, 0, 1, 32'hA5A5_5A5A, 1, "R8 hi only keeps lo");
      // R10: shift and write on the same index, then on different indices
      op(1, 0, 6'd4, 0, 3, 1, 1, 3, 32'hDEAD_BEEF, 3, "R10 same index write dropped");
      op(1, 0, 6'd1, 0, 2, 1, 1, 0, 32'h1234_5678, 0, "R10 other index write kept");
      op(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, "R10 shifted entry");
      idle();
      drain();

      // R9: read port follows rd_idx with no clock edge
      for (int i = 0; i < 4; i++) begin
         rd_idx = 2'(i);
         #0.5;
         n_chk++;
         if (rd_hi !== model[i][63:32] || rd_lo !== model[i][31:0]) begin
            n_fail++;
            $display("FAIL R9: got hi=%h lo=%h expected hi=%h lo=%h",
                     rd_hi, rd_lo, model[i][63:32], model[i][31:0]);
         end
      end

      // R3 R4 R5 R7 R11: every code on every index against the model
      for (int ix = 0; ix < 4; ix++) begin
         for (int a = 0; a < 64; a++) begin
            logic [31:0] h;
            logic [31:0] l;
            logic [31:0] up;
            string       t;
            h  = $urandom();
            l  = $urandom();
            up = $urandom();
            if (a == 0)       t = "R5 zero amount";
            else if (a < 32)  t = "R3 right shift";
            else              t = "R4 left shift";
            op(0, 0, 0, 0, 0, 1, 0, 2'(ix), h, 2'(ix), "R8 load hi");
            op(0, 0, 0, 0, 0, 0, 1, 2'(ix), l, 2'(ix), "R8 load lo");
            if (a % 2 == 1) begin
               op(1, 1, 6'h2A, {up[31:6], 6'(a)}, 2'(ix), 0, 0, 0, 0, 2'(ix), t);
            end else begin
               op(1, 0, 6'(a), up, 2'(ix), 0, 0, 0, 0, 2'(ix), t);
            end
            op(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'(ix + 1), "R7 neighbour unchanged");
         end
      end
      idle();
      drain();
      repeat (2) @(negedge clk);
      done = 1'b1;
      report();
      $finish;
   end

endmodule